// File: doc/BRIEF.md
# Transmit and Receive Descriptor Ring Engine

This block keeps two circular rings of packet descriptors, one for transmit and one for receive, in a small internal register file. Each descriptor is a single flags word. The word holds a hardware-ownership bit, start-of-packet and end-of-packet markers, and a length. Software hands a descriptor to the engine by writing it with the ownership bit set. The engine hands it back by clearing that bit. Software reads any descriptor back through a combinational read port.

For transmit, software posts descriptors and then pulses a wakeup strobe. The engine walks the ring from its head. Each owned descriptor is offered on a send handshake, and the engine clears its ownership when the sender reports completion. A reclaim walker follows behind the head and retires finished descriptors from a busy count. While that count equals the number of transmit buffers, the engine reports the ring as full and drops further owned posts.

For receive, each incoming frame fills the next owned receive descriptor with its length. A frame that arrives while the next descriptor is not owned is dropped. When software releases a consumed receive descriptor, the engine re-arms the entry that lies one buffer count ahead. Sticky interrupt and error status bits are cleared by writing 1 to them.

Top module: `ring_desc_engine`

## Requirements
- R1: After reset every descriptor word in both rings reads 0, no send is offered, the full flag is 0 and all four status bits are 0.
- R2: A descriptor word is 14 bits: bit 13 is ownership (1 = hardware), bit 12 is start-of-packet, bit 11 is end-of-packet and bits 10:0 are the length. A software write lands in the ring that `swWrRing` selects (0 = transmit, 1 = receive) and reads back unchanged from that ring only.
- R3: Sends start only after a `txWake` pulse. The engine then offers each owned transmit descriptor in ring order on `txReqValid`, with its index and length. The offer is held until `txDone`. The walk stops at the first descriptor that is not owned.
- R4: On `txDone` for an offered descriptor, its ownership bit is cleared, its other fields are kept, and `txIrq` is set.
- R5: Transmit and receive ring indices wrap from RING_MAX-1 to 0.
- R6: The reclaim walker retires transmit descriptors from the tail while they are no longer owned and the busy count is non-zero. It stops at the first descriptor that is still owned.
- R7: When the busy count equals TX_BUFS, `txFull` is 1 and a software write with the ownership bit set to the transmit ring is ignored.
- R8: A received frame whose head receive descriptor is owned writes that descriptor with ownership 0, start and end bits 1 and the frame length. It then advances the head and sets `rxIrq`.
- R9: A received frame whose head receive descriptor is not owned leaves the descriptor and the head unchanged and sets the sticky `rxDropSts`.
- R10: A frame longer than the descriptor's length field is stored with that length and sets the sticky `rxTruncSts`.
- R11: An `rxRelease` pulse rewrites the receive entry (tail + RX_BUFS) mod RING_MAX with ownership 1, start and end bits 0 and length BUF_SIZE, then advances the release tail.
- R12: `stsClr` clears status bits when written with 1: bit 0 `txIrq`, bit 1 `rxIrq`, bit 2 `rxDropSts`, bit 3 `rxTruncSts`. A set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| swWrEn | input | 1 | Software descriptor write strobe |
| swWrRing | input | 1 | Write ring select, 0 transmit, 1 receive |
| swWrIdx | input | IDX_W | Write descriptor index |
| swWrData | input | LEN_W+3 | Descriptor word to write |
| swRdRing | input | 1 | Read ring select |
| swRdIdx | input | IDX_W | Read descriptor index |
| swRdData | output | LEN_W+3 | Descriptor word read back |
| txWake | input | 1 | Transmit wakeup strobe |
| txReqValid | output | 1 | Send offer valid |
| txReqIdx | output | IDX_W | Index of offered descriptor |
| txReqLen | output | LEN_W | Length of offered descriptor |
| txDone | input | 1 | Sender completion for the offer |
| txFull | output | 1 | Transmit ring full |
| rxValid | input | 1 | Received frame strobe |
| rxLen | input | LEN_W | Received frame length |
| rxRelease | input | 1 | Software release of one receive descriptor |
| stsClr | input | 4 | Write-1-to-clear of status bits |
| txIrq | output | 1 | Transmit interrupt status |
| rxIrq | output | 1 | Receive interrupt status |
| rxDropSts | output | 1 | Sticky dropped-frame status |
| rxTruncSts | output | 1 | Sticky truncated-frame status |

## Verification
Transmit is driven four ways, and each isolates one behaviour:
- A single post held back until the wakeup separates wakeup gating from ownership scanning.
- A burst of back-to-back owned descriptors shows that the walk continues in ring order and stops at an unowned entry.
- A ring filled to the buffer count, plus one extra post, shows the full flag, the ignored post, and reclaim stopping at owned entries.
- A run across the top index exposes any wrap error.

Receive is driven with three kinds of frame:
- A frame with nothing owned shows the drop path.
- A short frame shows a normal fill.
- An oversized frame shows truncation.

Release pulses show which entry is re-armed. A long sequence of frames carries the receive head past the last index, to show that it wraps.

// File: rtl/ring_desc_pkg.sv
package ring_desc_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SCAN = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;

  // Write strobes from the sequencer to the descriptor store
  typedef struct packed {
    logic txPostOk;  // software transmit write accepted
    logic txClr;     // clear ownership at transmit head
    logic rxFill;    // fill receive head with frame length
    logic rxArm;     // re-arm receive entry ahead of release tail
  } ring_strobe_t;

endpackage

// File: rtl/ring_desc_store.sv
module ring_desc_store
  import ring_desc_pkg::*;
#(
  parameter int RING_MAX = 16,
  parameter int LEN_W    = 11,
  parameter int BUF_SIZE = 1536,
  localparam int IDX_W   = $clog2(RING_MAX),
  localparam int WORD_W  = LEN_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ring_strobe_t      st,
  input  logic              swWrEn,
  input  logic              swWrRing,
  input  logic [IDX_W-1:0]  swWrIdx,
  input  logic [WORD_W-1:0] swWrData,
  input  logic              swRdRing,
  input  logic [IDX_W-1:0]  swRdIdx,
  output logic [WORD_W-1:0] swRdData,
  input  logic [IDX_W-1:0]  txHead,
  input  logic [IDX_W-1:0]  txTail,
  input  logic [IDX_W-1:0]  rxHead,
  input  logic [IDX_W-1:0]  rxArmIdx,
  input  logic [LEN_W-1:0]  rxFillLen,
  output logic              txHeadOwn,
  output logic [LEN_W-1:0]  txHeadLen,
  output logic              txTailOwn,
  output logic              rxHeadOwn,
  output logic [LEN_W-1:0]  rxHeadLen
);

  localparam int OWN_B = LEN_W + 2;
  localparam logic [LEN_W-1:0] ARM_LEN = LEN_W'(BUF_SIZE);

  logic [WORD_W-1:0] txMem [RING_MAX];
  logic [WORD_W-1:0] rxMem [RING_MAX];

  // Engine writes come after software writes so they take precedence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < RING_MAX; i++) begin
        txMem[i] <= '0;
        rxMem[i] <= '0;
      end
    end else begin
      if (st.txPostOk)          txMem[swWrIdx] <= swWrData;
      if (swWrEn && swWrRing)   rxMem[swWrIdx] <= swWrData;
      if (st.txClr)             txMem[txHead][OWN_B] <= 1'b0;
      if (st.rxFill)            rxMem[rxHead] <= {3'b011, rxFillLen};
      if (st.rxArm)             rxMem[rxArmIdx] <= {3'b100, ARM_LEN};
    end
  end

  always_comb begin
    swRdData  = swRdRing ? rxMem[swRdIdx] : txMem[swRdIdx];
    txHeadOwn = txMem[txHead][OWN_B];
    txHeadLen = txMem[txHead][LEN_W-1:0];
    txTailOwn = txMem[txTail][OWN_B];
    rxHeadOwn = rxMem[rxHead][OWN_B];
    rxHeadLen = rxMem[rxHead][LEN_W-1:0];
  end

endmodule

// File: rtl/ring_desc_ctrl.sv
module ring_desc_ctrl
  import ring_desc_pkg::*;
#(
  parameter int RING_MAX = 16,
  parameter int TX_BUFS  = 8,
  parameter int RX_BUFS  = 8,
  parameter int LEN_W    = 11,
  localparam int IDX_W   = $clog2(RING_MAX)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swWrEn,
  input  logic             swWrRing,
  input  logic             swWrOwn,
  input  logic             txWake,
  input  logic             txDone,
  input  logic             rxValid,
  input  logic [LEN_W-1:0] rxLen,
  input  logic             rxRelease,
  input  logic [3:0]       stsClr,
  input  logic             txHeadOwn,
  input  logic [LEN_W-1:0] txHeadLen,
  input  logic             txTailOwn,
  input  logic             rxHeadOwn,
  input  logic [LEN_W-1:0] rxHeadLen,
  output ring_strobe_t     st,
  output logic [IDX_W-1:0] txHead,
  output logic [IDX_W-1:0] txTail,
  output logic [IDX_W-1:0] rxHead,
  output logic [IDX_W-1:0] rxArmIdx,
  output logic [LEN_W-1:0] rxFillLen,
  output logic             txReqValid,
  output logic [IDX_W-1:0] txReqIdx,
  output logic [LEN_W-1:0] txReqLen,
  output logic             txFull,
  output logic             txIrq,
  output logic             rxIrq,
  output logic             rxDropSts,
  output logic             rxTruncSts
);

  localparam int CNT_W = $clog2(TX_BUFS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(TX_BUFS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_MAX - 1);
  localparam logic [IDX_W:0]   RX_OFF   = (IDX_W+1)'(RX_BUFS);
  localparam logic [IDX_W:0]   RMAX     = (IDX_W+1)'(RING_MAX);

  tx_state_e        txState;
  logic [CNT_W-1:0] txBusy;
  logic [IDX_W-1:0] rxTail;
  logic [IDX_W:0]   armSum;
  logic             postAcc;
  logic             reclaim;
  logic             rxTooBig;

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] i);
    return (i == LAST_IDX) ? '0 : i + 1'b1;
  endfunction

  always_comb begin
    txFull      = (txBusy == FULL_CNT);
    postAcc     = swWrEn && !swWrRing && swWrOwn && !txFull;
    st.txPostOk = swWrEn && !swWrRing && (!swWrOwn || !txFull);
    st.txClr    = (txState == TX_SEND) && txDone;
    reclaim     = (txBusy != '0) && !txTailOwn;
    rxTooBig    = rxLen > rxHeadLen;
    st.rxFill   = rxValid && rxHeadOwn;
    rxFillLen   = rxTooBig ? rxHeadLen : rxLen;
    st.rxArm    = rxRelease;
    armSum      = {1'b0, rxTail} + RX_OFF;
    rxArmIdx    = (armSum >= RMAX) ? IDX_W'(armSum - RMAX) : armSum[IDX_W-1:0];
    txReqValid  = (txState == TX_SEND);
    txReqIdx    = txHead;
    txReqLen    = txHeadLen;
  end

  // Transmit walker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txHead  <= '0;
    end else begin
      unique case (txState)
        TX_IDLE: if (txWake) txState <= TX_SCAN;
        TX_SCAN: txState <= txHeadOwn ? TX_SEND : TX_IDLE;
        TX_SEND: if (txDone) begin
          txHead  <= stepIdx(txHead);
          txState <= TX_SCAN;
        end
        default: txState <= TX_IDLE;
      endcase
    end
  end

  // Reclaim walker and busy count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txTail <= '0;
      txBusy <= '0;
    end else begin
      if (reclaim) txTail <= stepIdx(txTail);
      unique case ({postAcc, reclaim})
        2'b10:   txBusy <= txBusy + 1'b1;
        2'b01:   txBusy <= txBusy - 1'b1;
        default: txBusy <= txBusy;
      endcase
    end
  end

  // Receive head and release tail
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHead <= '0;
      rxTail <= '0;
    end else begin
      if (st.rxFill) rxHead <= stepIdx(rxHead);
      if (rxRelease) rxTail <= stepIdx(rxTail);
    end
  end

  // Sticky status, set wins over write-1-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txIrq      <= 1'b0;
      rxIrq      <= 1'b0;
      rxDropSts  <= 1'b0;
      rxTruncSts <= 1'b0;
    end else begin
      txIrq      <= st.txClr  | (txIrq & ~stsClr[0]);
      rxIrq      <= st.rxFill | (rxIrq & ~stsClr[1]);
      rxDropSts  <= (rxValid && !rxHeadOwn) | (rxDropSts & ~stsClr[2]);
      rxTruncSts <= (st.rxFill && rxTooBig) | (rxTruncSts & ~stsClr[3]);
    end
  end

endmodule

// File: rtl/ring_desc_engine.sv
module ring_desc_engine
  import ring_desc_pkg::*;
#(
  parameter int RING_MAX = 16,
  parameter int TX_BUFS  = 8,
  parameter int RX_BUFS  = 8,
  parameter int LEN_W    = 11,
  parameter int BUF_SIZE = 1536,
  localparam int IDX_W   = $clog2(RING_MAX),
  localparam int WORD_W  = LEN_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swWrEn,
  input  logic              swWrRing,
  input  logic [IDX_W-1:0]  swWrIdx,
  input  logic [WORD_W-1:0] swWrData,
  input  logic              swRdRing,
  input  logic [IDX_W-1:0]  swRdIdx,
  output logic [WORD_W-1:0] swRdData,
  input  logic              txWake,
  output logic              txReqValid,
  output logic [IDX_W-1:0]  txReqIdx,
  output logic [LEN_W-1:0]  txReqLen,
  input  logic              txDone,
  output logic              txFull,
  input  logic              rxValid,
  input  logic [LEN_W-1:0]  rxLen,
  input  logic              rxRelease,
  input  logic [3:0]        stsClr,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              rxDropSts,
  output logic              rxTruncSts
);

  ring_strobe_t     st;
  logic [IDX_W-1:0] txHead, txTail, rxHead, rxArmIdx;
  logic [LEN_W-1:0] rxFillLen, txHeadLen, rxHeadLen;
  logic             txHeadOwn, txTailOwn, rxHeadOwn;

  ring_desc_ctrl #(
    .RING_MAX(RING_MAX), .TX_BUFS(TX_BUFS), .RX_BUFS(RX_BUFS), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .swWrEn(swWrEn), .swWrRing(swWrRing), .swWrOwn(swWrData[WORD_W-1]),
    .txWake(txWake), .txDone(txDone),
    .rxValid(rxValid), .rxLen(rxLen), .rxRelease(rxRelease), .stsClr(stsClr),
    .txHeadOwn(txHeadOwn), .txHeadLen(txHeadLen), .txTailOwn(txTailOwn),
    .rxHeadOwn(rxHeadOwn), .rxHeadLen(rxHeadLen),
    .st(st), .txHead(txHead), .txTail(txTail), .rxHead(rxHead),
    .rxArmIdx(rxArmIdx), .rxFillLen(rxFillLen),
    .txReqValid(txReqValid), .txReqIdx(txReqIdx), .txReqLen(txReqLen),
    .txFull(txFull), .txIrq(txIrq), .rxIrq(rxIrq),
    .rxDropSts(rxDropSts), .rxTruncSts(rxTruncSts)
  );

  ring_desc_store #(
    .RING_MAX(RING_MAX), .LEN_W(LEN_W), .BUF_SIZE(BUF_SIZE)
  ) u_store (
    .clk(clk), .rstN(rstN), .st(st),
    .swWrEn(swWrEn), .swWrRing(swWrRing), .swWrIdx(swWrIdx), .swWrData(swWrData),
    .swRdRing(swRdRing), .swRdIdx(swRdIdx), .swRdData(swRdData),
    .txHead(txHead), .txTail(txTail), .rxHead(rxHead),
    .rxArmIdx(rxArmIdx), .rxFillLen(rxFillLen),
    .txHeadOwn(txHeadOwn), .txHeadLen(txHeadLen), .txTailOwn(txTailOwn),
    .rxHeadOwn(rxHeadOwn), .rxHeadLen(rxHeadLen)
  );

endmodule

// File: rtl/ring_desc_engine_chk.sv
module ring_desc_engine_chk #(
  parameter int IDX_W = 4,
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             txReqValid,
  input logic [IDX_W-1:0] txReqIdx,
  input logic [LEN_W-1:0] txReqLen,
  input logic             txDone,
  input logic             txIrq,
  input logic [3:0]       stsClr,
  input logic             rxValid,
  input logic             rxIrq,
  input logic             rxDropSts
);

  assert_offer_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    txReqValid && !txDone |=> txReqValid && $stable(txReqIdx) && $stable(txReqLen));

  assert_done_irq_R4: assert property (@(posedge clk) disable iff (!rstN)
    txReqValid && txDone |=> txIrq);

  assert_tx_w1c_R12: assert property (@(posedge clk) disable iff (!rstN)
    stsClr[0] && !(txReqValid && txDone) |=> !txIrq);

  // every frame ends as a fill (R8) or a drop (R9)
  assert_rx_outcome_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> rxIrq || rxDropSts);

endmodule

bind ring_desc_engine ring_desc_engine_chk #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .txReqValid(txReqValid), .txReqIdx(txReqIdx),
  .txReqLen(txReqLen), .txDone(txDone), .txIrq(txIrq), .stsClr(stsClr),
  .rxValid(rxValid), .rxIrq(rxIrq), .rxDropSts(rxDropSts)
);

// File: tb/sim_ring_desc_engine.sv
`timescale 1ns/1ps
module sim_ring_desc_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swWrEn = 1'b0, swWrRing = 1'b0, swRdRing = 1'b0;
  logic [3:0]  swWrIdx = '0, swRdIdx = '0;
  logic [13:0] swWrData = '0;
  logic [13:0] swRdData;
  logic        txWake = 1'b0, txDone = 1'b0, rxValid = 1'b0, rxRelease = 1'b0;
  logic        txReqValid, txFull, txIrq, rxIrq, rxDropSts, rxTruncSts;
  logic [3:0]  txReqIdx;
  logic [10:0] txReqLen;
  logic [10:0] rxLen = '0;
  logic [3:0]  stsClr = '0;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ring_desc_engine u0 (
    .clk(clk), .rstN(rstN), .swWrEn(swWrEn), .swWrRing(swWrRing), .swWrIdx(swWrIdx),
    .swWrData(swWrData), .swRdRing(swRdRing), .swRdIdx(swRdIdx), .swRdData(swRdData),
    .txWake(txWake), .txReqValid(txReqValid), .txReqIdx(txReqIdx), .txReqLen(txReqLen),
    .txDone(txDone), .txFull(txFull), .rxValid(rxValid), .rxLen(rxLen),
    .rxRelease(rxRelease), .stsClr(stsClr), .txIrq(txIrq), .rxIrq(rxIrq),
    .rxDropSts(rxDropSts), .rxTruncSts(rxTruncSts)
  );

  function automatic logic [13:0] w(bit own, bit sop, bit eop, int len);
    return {own, sop, eop, 11'(len)};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wrDesc(bit ring, int idx, logic [13:0] d);
    swWrEn = 1'b1; swWrRing = ring; swWrIdx = 4'(idx); swWrData = d;
    @(negedge clk);
    swWrEn = 1'b0;
  endtask

  task automatic rdDesc(bit ring, int idx, output logic [13:0] d);
    swRdRing = ring; swRdIdx = 4'(idx);
    #1 d = swRdData;
  endtask

  task automatic wake();
    txWake = 1'b1; @(negedge clk); txWake = 1'b0;
  endtask

  task automatic recv(int len);
    rxValid = 1'b1; rxLen = 11'(len); @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic release1();
    rxRelease = 1'b1; @(negedge clk); rxRelease = 1'b0;
  endtask

  task automatic clearSts(logic [3:0] m);
    stsClr = m; @(negedge clk); stsClr = '0;
  endtask

  task automatic sendOne(int expIdx, int expLen, string req);
    int n = 0;
    while (!txReqValid && n < 20) begin @(negedge clk); n++; end
    chk(req, "offer valid", int'(txReqValid), 1);
    chk(req, "offer idx", int'(txReqIdx), expIdx);
    chk(req, "offer len", int'(txReqLen), expLen);
    txDone = 1'b1; @(negedge clk); txDone = 1'b0;
  endtask

  task automatic tReset();
    logic [13:0] d;
    int bad = 0;
    for (int i = 0; i < 16; i++) begin
      rdDesc(0, i, d); if (d != 0) bad++;
      rdDesc(1, i, d); if (d != 0) bad++;
    end
    chk("R1", "nonzero words", bad, 0);
    chk("R1", "txReqValid", int'(txReqValid), 0);
    chk("R1", "txFull", int'(txFull), 0);
    chk("R1", "status", int'({txIrq, rxIrq, rxDropSts, rxTruncSts}), 0);
  endtask

  task automatic tAccess();
    logic [13:0] d;
    wrDesc(1, 5, w(0, 1, 0, 33));
    rdDesc(1, 5, d); chk("R2", "rx readback", int'(d), int'(w(0, 1, 0, 33)));
    rdDesc(0, 5, d); chk("R2", "other ring", int'(d), 0);
  endtask

  task automatic tTxBasic();
    logic [13:0] d;
    wrDesc(0, 0, w(1, 1, 1, 100));
    repeat (5) @(negedge clk);
    chk("R3", "no send before wake", int'(txReqValid), 0);
    wake();
    sendOne(0, 100, "R3");
    rdDesc(0, 0, d); chk("R4", "own cleared", int'(d), int'(w(0, 1, 1, 100)));
    chk("R4", "txIrq", int'(txIrq), 1);
    repeat (4) @(negedge clk);
    chk("R3", "stop at unowned", int'(txReqValid), 0);
  endtask

  task automatic tStsClear();
    clearSts(4'b0001);
    chk("R12", "txIrq cleared", int'(txIrq), 0);
  endtask

  task automatic tTxBurst();
    wrDesc(0, 1, w(1, 1, 1, 64));
    wrDesc(0, 2, w(1, 1, 1, 65));
    wrDesc(0, 3, w(1, 1, 1, 1500));
    wake();
    sendOne(1, 64, "R3");
    sendOne(2, 65, "R3");
    sendOne(3, 1500, "R3");
    repeat (4) @(negedge clk);
    chk("R3", "burst ends", int'(txReqValid), 0);
  endtask

  task automatic tTxFull();
    logic [13:0] d;
    for (int i = 4; i < 12; i++) wrDesc(0, i, w(1, 1, 1, 200 + i));
    chk("R7", "full after 8 posts", int'(txFull), 1);
    wrDesc(0, 12, w(1, 1, 1, 999));
    rdDesc(0, 12, d); chk("R7", "post while full ignored", int'(d), 0);
    repeat (3) @(negedge clk);
    chk("R6", "owned not reclaimed", int'(txFull), 1);
    wake();
    sendOne(4, 204, "R6");
    repeat (2) @(negedge clk);
    chk("R6", "reclaimed after send", int'(txFull), 0);
    for (int i = 5; i < 12; i++) sendOne(i, 200 + i, "R3");
    repeat (3) @(negedge clk);
  endtask

  task automatic tTxWrap();
    for (int i = 12; i < 16; i++) wrDesc(0, i, w(1, 1, 1, 300 + i));
    wrDesc(0, 0, w(1, 1, 1, 400));
    wake();
    for (int i = 12; i < 16; i++) sendOne(i, 300 + i, "R5");
    sendOne(0, 400, "R5");
    repeat (3) @(negedge clk);
    chk("R6", "all reclaimed", int'(txFull), 0);
  endtask

  task automatic tRxDrop();
    logic [13:0] d;
    recv(50);
    chk("R9", "drop sticky", int'(rxDropSts), 1);
    chk("R9", "no rxIrq", int'(rxIrq), 0);
    rdDesc(1, 0, d); chk("R9", "desc unchanged", int'(d), 0);
    clearSts(4'b0100);
    chk("R12", "drop cleared", int'(rxDropSts), 0);
  endtask

  task automatic tRxFill();
    logic [13:0] d;
    for (int i = 0; i < 8; i++) wrDesc(1, i, w(1, 0, 0, 1536));
    recv(60);
    rdDesc(1, 0, d); chk("R8", "fill head not advanced by drop", int'(d), int'(w(0, 1, 1, 60)));
    chk("R8", "rxIrq", int'(rxIrq), 1);
    chk("R10", "no trunc on short", int'(rxTruncSts), 0);
    recv(2000);
    rdDesc(1, 1, d); chk("R10", "truncated len", int'(d), int'(w(0, 1, 1, 1536)));
    chk("R10", "trunc sticky", int'(rxTruncSts), 1);
    clearSts(4'b1010);
    chk("R12", "rx bits cleared", int'({rxIrq, rxTruncSts}), 0);
  endtask

  task automatic tRxArm();
    logic [13:0] d;
    rdDesc(1, 8, d); chk("R11", "entry 8 before", int'(d), 0);
    release1();
    rdDesc(1, 8, d); chk("R11", "entry 8 armed", int'(d), int'(w(1, 0, 0, 1536)));
    release1();
    rdDesc(1, 9, d); chk("R11", "entry 9 armed", int'(d), int'(w(1, 0, 0, 1536)));
  endtask

  task automatic tRxWrap();
    logic [13:0] d;
    for (int i = 10; i < 16; i++) wrDesc(1, i, w(1, 0, 0, 1536));
    for (int i = 2; i < 16; i++) recv(100 + i);
    rdDesc(1, 15, d); chk("R8", "last entry filled", int'(d), int'(w(0, 1, 1, 115)));
    wrDesc(1, 0, w(1, 0, 0, 1536));
    recv(77);
    rdDesc(1, 0, d); chk("R5", "rx head wrapped", int'(d), int'(w(0, 1, 1, 77)));
    chk("R9", "no drop after wrap", int'(rxDropSts), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tAccess();
    tTxBasic();
    tStsClear();
    tTxBurst();
    tTxFull();
    tTxWrap();
    tRxDrop();
    tRxFill();
    tRxArm();
    tRxWrap();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule